// File: doc/BRIEF.md
# Privilege and Access Violation Checker

This block sits beside the decode and address-generation stages of a processor pipeline. Each cycle it receives one request made of the current privilege mode, two decode flags and an optional memory access. The decode flags mark an instruction that touches the system-control coprocessor registers and an opcode that is not defined. The memory access is an address tagged as an instruction fetch, a data load, a data store or no access at all. It decides whether the request breaks the privilege rules and, one clock later, raises a single violation strobe with a 5-bit exception cause code.

The address space splits in two halves. The lower half is open to both modes. The upper half is reserved for the privileged mode. User-mode access to the upper half is reported as an address error, with one code for reads (fetch or load) and another for stores. A control-register instruction issued in user mode, or any undefined opcode, is reported with the reserved-instruction code. When both an address error and a reserved-instruction fault appear in the same request, the reserved-instruction code wins. Later exception sequencing uses the registered result.

Top module: `priv_violation_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `viol_valid` is 0 and `viol_cause` is 0.
- R2: With `user_mode` = 0 (kernel), no address error and no control-register violation is raised for any address or access kind.
- R3: With `user_mode` = 1, a fetch (`acc_kind` = 0) or load (`acc_kind` = 1) to an address whose top bit is 1 (0x80000000 and above) gives `viol_valid` = 1 and `viol_cause` = 4.
- R4: With `user_mode` = 1, a store (`acc_kind` = 2) to an address whose top bit is 1 gives `viol_valid` = 1 and `viol_cause` = 5.
- R5: With `user_mode` = 1, every access kind to an address whose top bit is 0 (up to 0x7FFFFFFF) raises no address error.
- R6: With `user_mode` = 1, `cp0_op` = 1 gives `viol_valid` = 1 and `viol_cause` = 10.
- R7: `undef_op` = 1 gives `viol_valid` = 1 and `viol_cause` = 10 in either mode.
- R8: When a reserved-instruction fault and an address error occur in one request, `viol_cause` is 10.
- R9: With `acc_kind` = 3 (no access), the address is ignored and no address error is raised.
- R10: With `req_valid` = 0 no violation is reported, whatever the other inputs hold. Whenever `viol_valid` is 0, `viol_cause` is 0.
- R11: The result for a request driven before a clock edge appears on the outputs right after that edge (one cycle latency), and is replaced at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| user_mode | input | 1 | Privilege mode: 0 kernel, 1 user |
| cp0_op | input | 1 | Decoded instruction reads or writes a control register |
| undef_op | input | 1 | Decoded opcode is undefined |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 none |
| addr | input | ADDR_W (32) | Access address |
| viol_valid | output | 1 | Registered violation strobe |
| viol_cause | output | CAUSE_W (5) | Registered cause code, 0 when no violation |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 5-bit cause with codes 4, 5 and 10. These put the exact split points 0x7FFFFFFF and 0x80000000, and the all-ones address, within reach of directed vectors. A bench-side linear feedback shift register then sweeps mode, flags, kind and address together. This reaches the overlapping-fault precedence cases and the gated-off requests many times over, and a queued expected model checks them all against the registered outputs.

// File: rtl/privchk_pkg.sv
package privchk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  // True when the access kind actually touches memory.
  function automatic logic kind_touches_mem(acc_kind_e k);
    return (k != ACC_NONE);
  endfunction

  // True when the access writes memory.
  function automatic logic kind_is_write(acc_kind_e k);
    return (k == ACC_STORE);
  endfunction

endpackage

// File: rtl/addr_region_chk.sv
module addr_region_chk
  import privchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              user_mode,
  input  acc_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_fault,
  output logic              fault_is_store
);

  localparam logic [ADDR_W-1:0] KERNEL_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

  // Upper half of the space is kernel-only; equivalent to testing the top bit.
  function automatic logic in_kernel_half(logic [ADDR_W-1:0] a);
    return (a >= KERNEL_BASE);
  endfunction

  logic touches;
  logic upper;

  always_comb begin
    touches        = kind_touches_mem(kind);
    upper          = in_kernel_half(addr);
    addr_fault     = user_mode && touches && upper;
    fault_is_store = kind_is_write(kind);
  end

endmodule

// File: rtl/instr_priv_chk.sv
module instr_priv_chk (
  input  logic user_mode,
  input  logic cp0_op,
  input  logic undef_op,
  output logic rsvd_fault,
  output logic priv_fault
);

  always_comb begin
    priv_fault = user_mode && cp0_op;
    rsvd_fault = undef_op || priv_fault;
  end

endmodule

// File: rtl/cause_encoder.sv
module cause_encoder #(
  parameter int              CAUSE_W       = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_ADDR_RD = 5'd4,
  parameter logic [CAUSE_W-1:0] CAUSE_ADDR_WR = 5'd5,
  parameter logic [CAUSE_W-1:0] CAUSE_RSVD    = 5'd10
) (
  input  logic               req_valid,
  input  logic               addr_fault,
  input  logic               fault_is_store,
  input  logic               rsvd_fault,
  output logic               hit,
  output logic [CAUSE_W-1:0] cause
);

  // Instruction-level fault outranks the address fault.
  function automatic logic [CAUSE_W-1:0] pick_cause(logic rf, logic af, logic st);
    if (rf)      return CAUSE_RSVD;
    else if (af) return st ? CAUSE_ADDR_WR : CAUSE_ADDR_RD;
    else         return '0;
  endfunction

  always_comb begin
    hit   = req_valid && (rsvd_fault || addr_fault);
    cause = hit ? pick_cause(rsvd_fault, addr_fault, fault_is_store) : '0;
  end

endmodule

// File: rtl/priv_violation_checker.sv
module priv_violation_checker
  import privchk_pkg::*;
#(
  parameter int                 ADDR_W        = 32,
  parameter int                 CAUSE_W       = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_ADDR_RD = 5'd4,
  parameter logic [CAUSE_W-1:0] CAUSE_ADDR_WR = 5'd5,
  parameter logic [CAUSE_W-1:0] CAUSE_RSVD    = 5'd10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               user_mode,
  input  logic               cp0_op,
  input  logic               undef_op,
  input  logic [1:0]         acc_kind,
  input  logic [ADDR_W-1:0]  addr,
  output logic               viol_valid,
  output logic [CAUSE_W-1:0] viol_cause
);

  acc_kind_e            kind;
  logic                 addr_fault;
  logic                 fault_is_store;
  logic                 rsvd_fault;
  logic                 priv_fault;
  logic                 hit;
  logic [CAUSE_W-1:0]   cause_nxt;

  assign kind = acc_kind_e'(acc_kind);

  addr_region_chk #(.ADDR_W(ADDR_W)) u_addr (
    .user_mode      (user_mode),
    .kind           (kind),
    .addr           (addr),
    .addr_fault     (addr_fault),
    .fault_is_store (fault_is_store)
  );

  instr_priv_chk u_instr (
    .user_mode  (user_mode),
    .cp0_op     (cp0_op),
    .undef_op   (undef_op),
    .rsvd_fault (rsvd_fault),
    .priv_fault (priv_fault)
  );

  cause_encoder #(
    .CAUSE_W       (CAUSE_W),
    .CAUSE_ADDR_RD (CAUSE_ADDR_RD),
    .CAUSE_ADDR_WR (CAUSE_ADDR_WR),
    .CAUSE_RSVD    (CAUSE_RSVD)
  ) u_enc (
    .req_valid      (req_valid),
    .addr_fault     (addr_fault),
    .fault_is_store (fault_is_store),
    .rsvd_fault     (rsvd_fault),
    .hit            (hit),
    .cause          (cause_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_cause <= '0;
    end else begin
      viol_valid <= hit;
      viol_cause <= cause_nxt;
    end
  end

endmodule

// File: rtl/priv_violation_checker_sva.sv
module priv_violation_checker_sva #(
  parameter int                 ADDR_W        = 32,
  parameter int                 CAUSE_W       = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_ADDR_RD = 5'd4,
  parameter logic [CAUSE_W-1:0] CAUSE_ADDR_WR = 5'd5,
  parameter logic [CAUSE_W-1:0] CAUSE_RSVD    = 5'd10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               user_mode,
  input logic               cp0_op,
  input logic               undef_op,
  input logic [1:0]         acc_kind,
  input logic [ADDR_W-1:0]  addr,
  input logic               viol_valid,
  input logic [CAUSE_W-1:0] viol_cause,
  input logic               addr_fault,
  input logic               rsvd_fault,
  input logic               priv_fault
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!viol_valid && viol_cause == '0));

  a_r2_kernel_no_addr_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> (!addr_fault && !priv_fault));

  a_r3_read_addr_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && !cp0_op && !undef_op && addr[ADDR_W-1] &&
     (acc_kind == 2'd0 || acc_kind == 2'd1))
    |=> (viol_valid && viol_cause == CAUSE_ADDR_RD));

  a_r4_store_addr_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && !cp0_op && !undef_op && addr[ADDR_W-1] && acc_kind == 2'd2)
    |=> (viol_valid && viol_cause == CAUSE_ADDR_WR));

  a_r5_user_low_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !addr[ADDR_W-1]) |-> !addr_fault);

  a_r6_user_cp0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && cp0_op) |=> (viol_valid && viol_cause == CAUSE_RSVD));

  a_r7_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && undef_op) |=> (viol_valid && viol_cause == CAUSE_RSVD));

  a_r8_rsvd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_fault && rsvd_fault) |=> (viol_cause == CAUSE_RSVD));

  a_r9_no_access_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd3) |-> !addr_fault);

  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !viol_valid);

  a_r10_cause_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_valid |-> (viol_cause == '0));

  a_r11_quiet_follows_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !addr_fault && !rsvd_fault) |=> !viol_valid);

endmodule

bind priv_violation_checker priv_violation_checker_sva #(
  .ADDR_W        (ADDR_W),
  .CAUSE_W       (CAUSE_W),
  .CAUSE_ADDR_RD (CAUSE_ADDR_RD),
  .CAUSE_ADDR_WR (CAUSE_ADDR_WR),
  .CAUSE_RSVD    (CAUSE_RSVD)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .user_mode  (user_mode),
  .cp0_op     (cp0_op),
  .undef_op   (undef_op),
  .acc_kind   (acc_kind),
  .addr       (addr),
  .viol_valid (viol_valid),
  .viol_cause (viol_cause),
  .addr_fault (addr_fault),
  .rsvd_fault (rsvd_fault),
  .priv_fault (priv_fault)
);

// File: tb/test_priv_violation_checker.sv
module test_priv_violation_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        user_mode = 1'b0;
  logic        cp0_op = 1'b0;
  logic        undef_op = 1'b0;
  logic [1:0]  acc_kind = 2'd3;
  logic [31:0] addr = '0;
  logic        viol_valid;
  logic [4:0]  viol_cause;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic       v;
    logic [4:0] c;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  priv_violation_checker i_priv_violation_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .user_mode  (user_mode),
    .cp0_op     (cp0_op),
    .undef_op   (undef_op),
    .acc_kind   (acc_kind),
    .addr       (addr),
    .viol_valid (viol_valid),
    .viol_cause (viol_cause)
  );

  // Independent model written from the requirements.
  function automatic exp_t model(logic v, logic um, logic cp, logic ud,
                                 logic [1:0] k, logic [31:0] a, string tag);
    exp_t e;
    e.tag = tag;
    e.v = 1'b0;
    e.c = 5'd0;
    if (v) begin
      if (ud || (um && cp)) begin
        e.v = 1'b1; e.c = 5'd10;
      end else if (um && k != 2'd3 && a > 32'h7FFF_FFFF) begin
        e.v = 1'b1;
        case (k)
          2'd2:    e.c = 5'd5;
          default: e.c = 5'd4;
        endcase
      end
    end
    return e;
  endfunction

  task automatic drive(logic v, logic um, logic cp, logic ud,
                       logic [1:0] k, logic [31:0] a, string tag);
    @(negedge clk);
    req_valid = v; user_mode = um; cp0_op = cp; undef_op = ud;
    acc_kind = k; addr = a;
    sb.push_back(model(v, um, cp, ud, k, a, tag));
  endtask

  task automatic check(string tag, logic av, logic [4:0] ac, logic ev, logic [4:0] ec);
    vectors++;
    if (av !== ev || ac !== ec) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
               tag, av, ac, ev, ec);
    end
  endtask

  // Monitor: each result appears right after the edge following its drive.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, viol_valid, viol_cause, e.v, e.c);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    // R1: outputs quiet in reset even with a faulting request present
    req_valid = 1'b1; user_mode = 1'b1; undef_op = 1'b1;
    repeat (3) @(posedge clk);
    #5 check("R1 in reset", viol_valid, viol_cause, 1'b0, 5'd0);
    @(negedge clk);
    req_valid = 1'b0; undef_op = 1'b0; user_mode = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #5 check("R1 after reset", viol_valid, viol_cause, 1'b0, 5'd0);

    // R2 kernel mode
    drive(1, 0, 0, 0, 2'd0, 32'h8000_0180, "R2 kernel fetch upper");
    drive(1, 0, 0, 0, 2'd2, 32'hFFFF_FFFF, "R2 kernel store top");
    drive(1, 0, 1, 0, 2'd1, 32'h9000_0000, "R2 kernel cp0 load");
    // R3 / R4
    drive(1, 1, 0, 0, 2'd0, 32'h8000_0000, "R3 user fetch base");
    drive(1, 1, 0, 0, 2'd1, 32'hFFFF_FFFC, "R3 user load top");
    drive(1, 1, 0, 0, 2'd2, 32'h8000_0004, "R4 user store");
    drive(1, 1, 0, 0, 2'd2, 32'hFFFF_FFFF, "R4 user store top");
    // R5
    drive(1, 1, 0, 0, 2'd1, 32'h7FFF_FFFF, "R5 user load boundary");
    drive(1, 1, 0, 0, 2'd2, 32'h0000_0000, "R5 user store zero");
    drive(1, 1, 0, 0, 2'd0, 32'h7FFF_FFFC, "R5 user fetch low");
    // R6 / R7
    drive(1, 1, 1, 0, 2'd1, 32'h0000_1000, "R6 user cp0");
    drive(1, 0, 0, 1, 2'd3, 32'h0, "R7 undef kernel");
    drive(1, 1, 0, 1, 2'd0, 32'h100, "R7 undef user");
    // R8 precedence
    drive(1, 1, 1, 0, 2'd0, 32'h8000_0000, "R8 cp0 plus fetch fault");
    drive(1, 1, 0, 1, 2'd2, 32'hC000_0000, "R8 undef plus store fault");
    // R9
    drive(1, 1, 0, 0, 2'd3, 32'h8000_0000, "R9 no access upper");
    // R10
    drive(0, 1, 1, 1, 2'd2, 32'hF000_0000, "R10 gated request");
    // R11 back-to-back alternation
    drive(1, 1, 0, 0, 2'd2, 32'h8000_0000, "R11 b2b fault");
    drive(1, 1, 0, 0, 2'd2, 32'h0000_0000, "R11 b2b clean");
    drive(1, 1, 0, 0, 2'd1, 32'h8000_0000, "R11 b2b fault again");

    // Pseudo-random sweep
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[3] | lfsr[9], lfsr[4], lfsr[5] & lfsr[11], lfsr[6] & lfsr[12] & lfsr[13],
            lfsr[8:7], {lfsr[2], lfsr[30:0]}, "R8 R10 random sweep");
    end

    drive(0, 0, 0, 0, 2'd3, 32'h0, "R10 drain");
    @(posedge clk); #6;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule